// File: doc/BRIEF.md
# Strobed Parallel Peripheral Port with Ready Handshake

This block lets an asynchronous host read and write one internal data latch across a shared bidirectional bus, using three active-low strobes: select, read and write. A host read turns the bus drivers on so the latch contents appear on the bus. A host write stores the bus value into the latch. Each host write also drops a ready flag, which the local controller raises again once it has consumed the data. This gives a simple request and acknowledge handshake between two clock domains.

The local side can load the latch, observe it at all times, and set the ready flag. A mode-select input, active low, turns the port behaviour on. While that input is high, the three strobes are only general-purpose inputs, reported as synchronized levels. In that case the bus drivers follow a local output-enable bit.

Top module: `hostport_slave`

## Requirements
- R1: While the select strobe (host_cs_n) is high, pulses on host_rd_n and host_wr_n change neither the latch nor rdy, and do not enable the bus drivers.
- R2: In port mode (port_mode_n low), once host_cs_n and host_rd_n have both been low for SYNC_STAGES+1 clock edges, bus_oe is 1 and bus_out equals the latch.
- R3: In port mode, bus_oe drops to 0 in the same cycle that host_rd_n or host_cs_n returns high, and no later than the next clock edge.
- R4: A host write (host_cs_n and host_wr_n low, then host_wr_n rising) stores the bus value held during the strobe. Data that changes after the rising edge is not stored. The new value appears on loc_latch no more than SYNC_STAGES+2 edges after the rise.
- R5: Each committed host write clears rdy, at the same edge where the latch is updated.
- R6: A loc_set_rdy pulse sets rdy at the next edge. If a host write commits in the same cycle, the host write wins and rdy is 0.
- R7: A loc_load pulse copies loc_data into the latch at the next edge. If a host write commits in the same cycle, the host data is stored instead.
- R8: With port_mode_n high, host strobes leave the latch and rdy untouched, and bus_oe follows loc_oe. strobe_lvl reports the synchronized strobe levels with bit 2 = write, bit 1 = select, bit 0 = read.
- R9: After reset the latch is 0, rdy is 0, bus_oe is 0 (in port mode with the strobes idle), and strobe_lvl is 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_mode_n | input | 1 | Low selects strobed port mode |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_cs_n | input | 1 | Host select strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| bus_in | input | DATA_W | Value sampled from the shared bus |
| bus_out | output | DATA_W | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus driver enable |
| loc_load | input | 1 | Local request to load the latch |
| loc_data | input | DATA_W | Local data for a load |
| loc_latch | output | DATA_W | Current latch contents |
| loc_oe | input | 1 | Driver enable used when port mode is off |
| loc_set_rdy | input | 1 | Local request to raise ready |
| rdy | output | 1 | Ready / interrupt handshake flag |
| strobe_lvl | output | 3 | Synchronized strobe levels {write, select, read} |

## Verification
The bench builds the port with an 8-bit bus and a three-stage synchronizer rather than the default two. This moves every commit and enable edge one cycle later, so a latency counted against a fixed two-stage pipeline would show up as an error. The deeper pipeline also lets the bench place a local load and a local ready request exactly on the cycle a host write commits, to test the collision priority. Bus data is changed right after the write strobe rises, to show that only data held during the strobe is captured.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int STB_RD = 0;
    localparam int STB_CS = 1;
    localparam int STB_WR = 2;
    localparam int STB_N  = 3;
    typedef logic [STB_N-1:0] strobe_t;
    localparam strobe_t STB_IDLE = '1;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;
    logic [STAGES-1:0][W-1:0] stg_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stg_d[g] = d;
        end else begin : g_next
            always_comb stg_d[g] = stg_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hp_wr_capture.sv
module hp_wr_capture #(
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cs_s,
    input  logic              wr_s,
    input  logic [DATA_W-1:0] data_in,
    output logic              commit,
    output logic [DATA_W-1:0] commit_data
);
    typedef struct packed {
        logic              act;
        logic [DATA_W-1:0] shadow;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [DATA_W-1:0] data_dly;

    // Data travels through the same depth as the strobes so both stay aligned.
    hp_sync #(.W(DATA_W), .STAGES(STAGES), .RST_VAL('0)) i_data_dly (
        .clk(clk), .rst_n(rst_n), .d(data_in), .q(data_dly)
    );

    always_comb begin
        cap_d        = cap_q;
        cap_d.act    = en && !cs_s && !wr_s;
        if (cap_d.act) cap_d.shadow = data_dly;
        commit       = en && cap_q.act && !cap_d.act;
        commit_data  = cap_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    // R4: a commit always ends a write window that was open the cycle before
    p_commit_after_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(en && !cs_s && !wr_s));
endmodule

// File: rtl/hostport_slave.sv
module hostport_slave #(
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_mode_n,
    input  logic              host_rd_n,
    input  logic              host_cs_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              loc_load,
    input  logic [DATA_W-1:0] loc_data,
    output logic [DATA_W-1:0] loc_latch,
    input  logic              loc_oe,
    input  logic              loc_set_rdy,
    output logic              rdy,
    output logic [2:0]        strobe_lvl
);
    import hp_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] latch;
        logic              rdy;
        logic              oe;
    } port_t;

    port_t   st_d, st_q;
    strobe_t stb_s;
    logic    port_on;
    logic    wr_commit;
    logic [DATA_W-1:0] wr_data;

    assign port_on = !port_mode_n;

    hp_sync #(.W(STB_N), .STAGES(SYNC_STAGES), .RST_VAL(STB_IDLE)) i_stb_sync (
        .clk(clk), .rst_n(rst_n),
        .d({host_wr_n, host_cs_n, host_rd_n}),
        .q(stb_s)
    );

    hp_wr_capture #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) i_wr_cap (
        .clk(clk), .rst_n(rst_n), .en(port_on),
        .cs_s(stb_s[STB_CS]), .wr_s(stb_s[STB_WR]),
        .data_in(bus_in),
        .commit(wr_commit), .commit_data(wr_data)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = port_on && !stb_s[STB_CS] && !stb_s[STB_RD];
        if (loc_load)    st_d.latch = loc_data;
        if (loc_set_rdy) st_d.rdy   = 1'b1;
        if (wr_commit) begin
            st_d.latch = wr_data;
            st_d.rdy   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Release uses the raw strobes so the drivers turn off without sync delay.
    assign bus_oe     = port_on ? (st_q.oe && !host_rd_n && !host_cs_n) : loc_oe;
    assign bus_out    = st_q.latch;
    assign loc_latch  = st_q.latch;
    assign rdy        = st_q.rdy;
    assign strobe_lvl = stb_s;

    p_cs_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_s[STB_CS] && $past(stb_s[STB_CS])) |-> !wr_commit);

    p_oe_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_on && (host_rd_n || host_cs_n)) |-> !bus_oe);

    p_hold_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_commit && !loc_load) |=> $stable(loc_latch));

    p_commit_clears_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !rdy);

    p_set_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_set_rdy && !wr_commit) |=> rdy);

    p_local_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_load && !wr_commit) |=> (loc_latch == $past(loc_data)));

    p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        port_mode_n |-> !wr_commit);
endmodule

// File: tb/test_hostport_slave.sv
module test_hostport_slave;
    localparam int DW = 8;
    localparam int NS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_mode_n = 1'b0;
    logic host_rd_n = 1'b1, host_cs_n = 1'b1, host_wr_n = 1'b1;
    logic [DW-1:0] bus_in = '0;
    logic [DW-1:0] bus_out;
    logic bus_oe;
    logic loc_load = 1'b0;
    logic [DW-1:0] loc_data = '0;
    logic [DW-1:0] loc_latch;
    logic loc_oe = 1'b0;
    logic loc_set_rdy = 1'b0;
    logic rdy;
    logic [2:0] strobe_lvl;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    hostport_slave #(.DATA_W(DW), .SYNC_STAGES(NS)) i_hostport_slave (
        .clk(clk), .rst_n(rst_n), .port_mode_n(port_mode_n),
        .host_rd_n(host_rd_n), .host_cs_n(host_cs_n), .host_wr_n(host_wr_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .loc_load(loc_load), .loc_data(loc_data), .loc_latch(loc_latch),
        .loc_oe(loc_oe), .loc_set_rdy(loc_set_rdy), .rdy(rdy),
        .strobe_lvl(strobe_lvl)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // host write; bus is changed right after the rising edge
    task automatic host_write(input logic [DW-1:0] v);
        @(negedge clk);
        bus_in = v; host_cs_n = 1'b0; host_wr_n = 1'b0;
        settle(NS + 2);
        host_wr_n = 1'b1; bus_in = ~v;
        settle(1);
        host_cs_n = 1'b1;
    endtask

    task automatic local_load(input logic [DW-1:0] v);
        @(negedge clk);
        loc_load = 1'b1; loc_data = v;
        @(negedge clk);
        loc_load = 1'b0;
    endtask

    task automatic set_ready();
        @(negedge clk);
        loc_set_rdy = 1'b1;
        @(negedge clk);
        loc_set_rdy = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check(loc_latch == 0, "R9 latch after reset", loc_latch, 0);
        check(rdy == 0, "R9 rdy after reset", rdy, 0);
        check(bus_oe == 0, "R9 bus_oe after reset", bus_oe, 0);
        check(strobe_lvl == 3'b111, "R9 strobe_lvl after reset", strobe_lvl, 3'b111);
    endtask

    task automatic t_local_load();
        local_load(8'h3C);
        #1;
        check(loc_latch == 8'h3C, "R7 local load", loc_latch, 8'h3C);
    endtask

    task automatic t_host_read();
        @(negedge clk);
        host_cs_n = 1'b0; host_rd_n = 1'b0;
        settle(NS + 2);
        #1;
        check(bus_oe == 1'b1, "R2 read enables bus", bus_oe, 1);
        check(bus_out == 8'h3C, "R2 read data", bus_out, 8'h3C);
        host_rd_n = 1'b1;
        #1;
        check(bus_oe == 1'b0, "R3 release on read rise", bus_oe, 0);
        settle(1);
        host_rd_n = 1'b0;
        settle(NS + 2);
        #1;
        check(bus_oe == 1'b1, "R2 second read enables bus", bus_oe, 1);
        host_cs_n = 1'b1;
        #1;
        check(bus_oe == 1'b0, "R3 release on select rise", bus_oe, 0);
        host_rd_n = 1'b1;
        settle(NS + 2);
    endtask

    task automatic t_host_write();
        set_ready();
        #1;
        check(rdy == 1'b1, "R6 set ready", rdy, 1);
        host_write(8'hA5);
        settle(NS + 2);
        #1;
        check(loc_latch == 8'hA5, "R4 write stores strobe data", loc_latch, 8'hA5);
        check(rdy == 1'b0, "R5 write clears ready", rdy, 0);
        host_write(8'h5A);
        settle(NS + 2);
        #1;
        check(loc_latch == 8'h5A, "R4 second write data", loc_latch, 8'h5A);
    endtask

    task automatic t_cs_gate();
        set_ready();
        @(negedge clk);
        bus_in = 8'hFF; host_wr_n = 1'b0; host_rd_n = 1'b0;
        settle(NS + 2);
        #1;
        check(bus_oe == 1'b0, "R1 no drive without select", bus_oe, 0);
        host_wr_n = 1'b1; host_rd_n = 1'b1;
        settle(NS + 3);
        #1;
        check(loc_latch == 8'h5A, "R1 latch unchanged without select", loc_latch, 8'h5A);
        check(rdy == 1'b1, "R1 ready unchanged without select", rdy, 1);
    endtask

    task automatic t_collision();
        // rdy is 1 here; commit lands NS edges after the strobe rise
        @(negedge clk);
        bus_in = 8'hC3; host_cs_n = 1'b0; host_wr_n = 1'b0;
        settle(NS + 2);
        host_wr_n = 1'b1; bus_in = 8'h00;
        settle(NS);
        loc_load = 1'b1; loc_data = 8'h11; loc_set_rdy = 1'b1;
        @(negedge clk);
        loc_load = 1'b0; loc_set_rdy = 1'b0; host_cs_n = 1'b1;
        #1;
        check(loc_latch == 8'hC3, "R7 host write beats local load", loc_latch, 8'hC3);
        check(rdy == 1'b0, "R6 host write beats set ready", rdy, 0);
        settle(NS + 2);
    endtask

    task automatic t_mode_off();
        set_ready();
        @(negedge clk);
        port_mode_n = 1'b1;
        loc_oe = 1'b1;
        #1;
        check(bus_oe == 1'b1, "R8 bus_oe follows loc_oe high", bus_oe, 1);
        loc_oe = 1'b0;
        #1;
        check(bus_oe == 1'b0, "R8 bus_oe follows loc_oe low", bus_oe, 0);
        host_write(8'h77);
        settle(NS + 3);
        #1;
        check(loc_latch == 8'hC3, "R8 latch untouched off mode", loc_latch, 8'hC3);
        check(rdy == 1'b1, "R8 ready untouched off mode", rdy, 1);
        @(negedge clk);
        host_rd_n = 1'b0; host_cs_n = 1'b1; host_wr_n = 1'b0;
        settle(NS + 1);
        #1;
        check(strobe_lvl == 3'b010, "R8 strobe levels", strobe_lvl, 3'b010);
        check(bus_oe == 1'b0, "R8 read ignored off mode", bus_oe, 0);
        host_rd_n = 1'b1; host_wr_n = 1'b1;
        settle(NS + 1);
        port_mode_n = 1'b0;
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        t_reset();
        t_local_load();
        t_host_read();
        t_host_write();
        t_cs_gate();
        t_collision();
        t_mode_off();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule